// File: doc/BRIEF.md
# CPU Special I/O Register Bank

This block holds the small set of core-side registers that sit at the top of an 8-bit processor's 64-entry I/O space, at addresses 0x38 to 0x3F. It covers four pointer-extension bytes, one extension byte for indirect jumps, the two stack pointer bytes and the status byte. The core reaches them through a byte-wide I/O read/write port. Each extension byte is presented already shifted into bits 23:16 of a 24-bit word. The core can OR that word straight onto a 16-bit pointer to form a wide address.

Four configuration inputs enable the optional pointer-extension registers, and a fifth enables the high stack-pointer byte. A write to a register that is switched off is discarded. The bank does not decode any other I/O address. Such an access goes out on an external peripheral bus at a base address plus the port number, with a one-cycle request strobe, and the peripheral returns its read data combinationally in the same cycle. The ALU's flag logic is outside this block. The status register here is only loaded and read as a whole byte.

Top module: `core_ioreg_bank`

## Requirements
- R1: After reset the five extension outputs and the status output are zero and the stack pointer equals the parameter SP_INIT.
- R2: A write to 0x38, 0x39, 0x3A or 0x3B, with the matching enable (cfg_dext_en, cfg_xext_en, cfg_yext_en, cfg_zext_en) high, places the data byte in bits 23:16 of ptr_ext_d, ptr_ext_x, ptr_ext_y or ptr_ext_z at the next clock edge, with bits 15:0 zero. A read of that address returns the byte.
- R3: A write to 0x38 to 0x3B while the matching enable is low leaves that extension output unchanged.
- R4: A write to 0x3C always loads bits 23:16 of jmp_ext, whatever the enables are, and a read of 0x3C returns that byte.
- R5: A write to 0x3D replaces stack_ptr[7:0] and keeps stack_ptr[15:8]. A read of 0x3D returns stack_ptr[7:0].
- R6: A read of 0x3E returns stack_ptr[15:8]. A write to 0x3E changes stack_ptr[15:8] only when cfg_sp16 is high.
- R7: A write to 0x3F loads the status byte at the next edge, and a read of 0x3F returns it.
- R8: An access to any address from 0x00 to 0x37 raises bus_req in that cycle. In that cycle bus_addr equals IO_BASE plus the address, bus_we equals io_wr, bus_wdata equals io_wdata, and io_rdata equals bus_rdata. Such an access leaves every local register unchanged.
- R9: An access to 0x38 to 0x3F never raises bus_req.
- R10: When a read and a write hit the same local register in one cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_dext_en | input | 1 | Enables the data-pointer extension register (0x38) |
| cfg_xext_en | input | 1 | Enables the X-pointer extension register (0x39) |
| cfg_yext_en | input | 1 | Enables the Y-pointer extension register (0x3A) |
| cfg_zext_en | input | 1 | Enables the Z-pointer extension register (0x3B) |
| cfg_sp16 | input | 1 | Enables writes to the high stack-pointer byte |
| io_addr | input | 6 | I/O port number |
| io_rd | input | 1 | I/O read |
| io_wr | input | 1 | I/O write |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| bus_req | output | 1 | Request strobe for a forwarded access |
| bus_we | output | 1 | Forwarded access is a write |
| bus_addr | output | 16 | Forwarded address, IO_BASE plus port |
| bus_wdata | output | 8 | Forwarded write data |
| bus_rdata | input | 8 | Read data from the peripheral bus |
| ptr_ext_d | output | 24 | Data-pointer extension, byte in 23:16 |
| ptr_ext_x | output | 24 | X-pointer extension, byte in 23:16 |
| ptr_ext_y | output | 24 | Y-pointer extension, byte in 23:16 |
| ptr_ext_z | output | 24 | Z-pointer extension, byte in 23:16 |
| jmp_ext | output | 24 | Indirect-jump extension, byte in 23:16 |
| stack_ptr | output | 16 | Stack pointer |
| status | output | 8 | Status byte |

## Verification
A read and a write can hit the same local register in one cycle. This happens when the core does a read-modify-write of the status byte. The bench raises both strobes together on 0x3F with new data. It expects io_rdata in that cycle to show the old byte and the status output after the edge to show the new byte. It also forwards a write together with a read to a peripheral address and checks that no local register moves.

// File: rtl/ioreg_pkg.sv
package ioreg_pkg;
  localparam int IO_AW     = 6;
  localparam int BYTE_W    = 8;
  localparam int LOCAL_N   = 8;
  localparam int NUM_EXT   = 5;
  localparam int PTR_W     = 16;
  localparam int EXT_W     = PTR_W + BYTE_W;
  localparam int SEL_W     = $clog2(LOCAL_N);
  localparam int PAGE_W    = IO_AW - SEL_W;
  localparam logic [PAGE_W-1:0] LOCAL_PAGE = '1;

  typedef enum logic [SEL_W-1:0] {
    SEL_EXT_D   = 3'd0,
    SEL_EXT_X   = 3'd1,
    SEL_EXT_Y   = 3'd2,
    SEL_EXT_Z   = 3'd3,
    SEL_EXT_JMP = 3'd4,
    SEL_SP_LO   = 3'd5,
    SEL_SP_HI   = 3'd6,
    SEL_STATUS  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/ioreg_rst_sync.sv
module ioreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ioreg_decode.sv
module ioreg_decode
  import ioreg_pkg::*;
#(
  parameter int BUS_AW = 16,
  parameter logic [BUS_AW-1:0] IO_BASE = 16'h0020
) (
  input  logic [IO_AW-1:0]   io_addr,
  input  logic               io_rd,
  input  logic               io_wr,
  output reg_sel_e           sel,
  output logic [LOCAL_N-1:0] wr_stb,
  output logic               bus_req,
  output logic               bus_we,
  output logic [BUS_AW-1:0]  bus_addr
);
  logic is_local;

  always_comb begin
    is_local = (io_addr[IO_AW-1:SEL_W] == LOCAL_PAGE);
    sel      = reg_sel_e'(io_addr[SEL_W-1:0]);
    wr_stb   = '0;
    if (is_local && io_wr) wr_stb[io_addr[SEL_W-1:0]] = 1'b1;
    bus_req  = !is_local && (io_rd || io_wr);
    bus_we   = !is_local && io_wr;
    bus_addr = IO_BASE + BUS_AW'(io_addr);
  end
endmodule

// File: rtl/ioreg_ext_reg.sv
module ioreg_ext_reg
  import ioreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              feat_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [EXT_W-1:0]  q_ext
);
  logic [BYTE_W-1:0] hi_q;
  logic              ld;

  always_comb begin
    ld = wr_en && feat_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  hi_q <= '0;
    else if (ld) hi_q <= wdata;
  end

  assign q_ext = {hi_q, {PTR_W{1'b0}}};

  // R2
  ext_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && feat_en) |=> (q_ext[EXT_W-1:PTR_W] == $past(wdata)));
  // R3
  ext_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !feat_en) |=> $stable(q_ext));
endmodule

// File: rtl/ioreg_stack.sv
module ioreg_stack
  import ioreg_pkg::*;
#(
  parameter logic [2*BYTE_W-1:0] SP_INIT = 16'h08FF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic                wide,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [2*BYTE_W-1:0] sp
);
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic              ld_lo, ld_hi;

  always_comb begin
    ld_lo = wr_lo;
    ld_hi = wr_hi && wide;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= SP_INIT[BYTE_W-1:0];
    else if (ld_lo) lo_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= SP_INIT[2*BYTE_W-1:BYTE_W];
    else if (ld_hi) hi_q <= wdata;
  end

  assign sp = {hi_q, lo_q};

  // R5
  sp_lo_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (sp[BYTE_W-1:0] == $past(wdata)) && $stable(sp[2*BYTE_W-1:BYTE_W]));
  // R6
  sp_hi_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wide) |=> $stable(sp));
endmodule

// File: rtl/core_ioreg_bank.sv
module core_ioreg_bank
  import ioreg_pkg::*;
#(
  parameter int BUS_AW = 16,
  parameter logic [BUS_AW-1:0] IO_BASE = 16'h0020,
  parameter logic [15:0] SP_INIT = 16'h08FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_dext_en,
  input  logic              cfg_xext_en,
  input  logic              cfg_yext_en,
  input  logic              cfg_zext_en,
  input  logic              cfg_sp16,
  input  logic [5:0]        io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [BUS_AW-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic [7:0]        bus_rdata,
  output logic [23:0]       ptr_ext_d,
  output logic [23:0]       ptr_ext_x,
  output logic [23:0]       ptr_ext_y,
  output logic [23:0]       ptr_ext_z,
  output logic [23:0]       jmp_ext,
  output logic [15:0]       stack_ptr,
  output logic [7:0]        status
);
  logic               rst_i_n;
  reg_sel_e           sel;
  logic [LOCAL_N-1:0] wr_stb;
  logic [NUM_EXT-1:0] ext_feat;
  logic [EXT_W-1:0]   ext_q [NUM_EXT];
  logic [BYTE_W-1:0]  status_q;
  logic               status_ld;

  ioreg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  ioreg_decode #(.BUS_AW(BUS_AW), .IO_BASE(IO_BASE)) u_dec (
    .io_addr  (io_addr),
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .sel      (sel),
    .wr_stb   (wr_stb),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr)
  );

  assign bus_wdata = io_wdata;
  assign ext_feat  = {1'b1, cfg_zext_en, cfg_yext_en, cfg_xext_en, cfg_dext_en};

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_ext
    ioreg_ext_reg u_ext (
      .clk     (clk),
      .rst_n   (rst_i_n),
      .wr_en   (wr_stb[i]),
      .feat_en (ext_feat[i]),
      .wdata   (io_wdata),
      .q_ext   (ext_q[i])
    );
  end

  assign ptr_ext_d = ext_q[SEL_EXT_D];
  assign ptr_ext_x = ext_q[SEL_EXT_X];
  assign ptr_ext_y = ext_q[SEL_EXT_Y];
  assign ptr_ext_z = ext_q[SEL_EXT_Z];
  assign jmp_ext   = ext_q[SEL_EXT_JMP];

  ioreg_stack #(.SP_INIT(SP_INIT)) u_sp (
    .clk   (clk),
    .rst_n (rst_i_n),
    .wr_lo (wr_stb[SEL_SP_LO]),
    .wr_hi (wr_stb[SEL_SP_HI]),
    .wide  (cfg_sp16),
    .wdata (io_wdata),
    .sp    (stack_ptr)
  );

  always_comb begin
    status_ld = wr_stb[SEL_STATUS];
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       status_q <= '0;
    else if (status_ld) status_q <= io_wdata;
  end

  assign status = status_q;

  always_comb begin
    io_rdata = bus_rdata;
    if (!bus_req) begin
      case (sel)
        SEL_EXT_D:   io_rdata = ext_q[SEL_EXT_D][EXT_W-1:PTR_W];
        SEL_EXT_X:   io_rdata = ext_q[SEL_EXT_X][EXT_W-1:PTR_W];
        SEL_EXT_Y:   io_rdata = ext_q[SEL_EXT_Y][EXT_W-1:PTR_W];
        SEL_EXT_Z:   io_rdata = ext_q[SEL_EXT_Z][EXT_W-1:PTR_W];
        SEL_EXT_JMP: io_rdata = ext_q[SEL_EXT_JMP][EXT_W-1:PTR_W];
        SEL_SP_LO:   io_rdata = stack_ptr[7:0];
        SEL_SP_HI:   io_rdata = stack_ptr[15:8];
        SEL_STATUS:  io_rdata = status_q;
        default:     io_rdata = bus_rdata;
      endcase
    end
  end

  // R7
  status_load_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (io_wr && io_addr == 6'h3F) |=> (status == $past(io_wdata)));
  // R8
  fwd_keeps_local_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_req |=> $stable(status) && $stable(stack_ptr) && $stable(jmp_ext));
  // R9
  local_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (io_addr[5:3] == 3'b111) |-> !bus_req);
  // R4
  jmp_always_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (io_wr && io_addr == 6'h3C) |=> (jmp_ext[23:16] == $past(io_wdata)));
endmodule

// File: tb/core_ioreg_bank_test.sv
module core_ioreg_bank_test;
  localparam logic [15:0] SP_INIT = 16'h08FF;
  localparam logic [15:0] IO_BASE = 16'h0020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_dext_en = 1'b0, cfg_xext_en = 1'b0, cfg_yext_en = 1'b0, cfg_zext_en = 1'b0;
  logic        cfg_sp16 = 1'b0;
  logic [5:0]  io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [23:0] ptr_ext_d, ptr_ext_x, ptr_ext_y, ptr_ext_z, jmp_ext;
  logic [15:0] stack_ptr;
  logic [7:0]  status;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  assign bus_rdata = bus_addr[7:0] ^ 8'hA5;

  core_ioreg_bank #(.BUS_AW(16), .IO_BASE(IO_BASE), .SP_INIT(SP_INIT)) uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    #1;
  endtask

  task automatic do_rd(input logic [5:0] a, output logic [7:0] v);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 v = io_rdata;
    io_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 ext_d", ptr_ext_d, 0);
    check("R1 ext_z", ptr_ext_z, 0);
    check("R1 jmp", jmp_ext, 0);
    check("R1 status", status, 0);
    check("R1 sp", stack_ptr, SP_INIT);
    do_rd(6'h3D, v); check("R1 sp lo read", v, SP_INIT[7:0]);
    do_rd(6'h3E, v); check("R6 sp hi read", v, SP_INIT[15:8]);
  endtask

  task automatic t_ext_enabled();
    logic [7:0] v;
    cfg_dext_en = 1; cfg_xext_en = 1; cfg_yext_en = 1; cfg_zext_en = 1;
    do_wr(6'h38, 8'h11); do_wr(6'h39, 8'h22); do_wr(6'h3A, 8'h33); do_wr(6'h3B, 8'h44);
    do_wr(6'h3C, 8'h55);
    check("R2 ext_d", ptr_ext_d, 24'h110000);
    check("R2 ext_x", ptr_ext_x, 24'h220000);
    check("R2 ext_y", ptr_ext_y, 24'h330000);
    check("R2 ext_z", ptr_ext_z, 24'h440000);
    check("R4 jmp", jmp_ext, 24'h550000);
    do_rd(6'h39, v); check("R2 read x", v, 8'h22);
    do_rd(6'h3B, v); check("R2 read z", v, 8'h44);
    do_rd(6'h3C, v); check("R4 read jmp", v, 8'h55);
  endtask

  task automatic t_ext_gated();
    logic [7:0] v;
    cfg_dext_en = 0; cfg_xext_en = 0; cfg_yext_en = 0; cfg_zext_en = 0;
    do_wr(6'h38, 8'hE1); do_wr(6'h39, 8'hE2); do_wr(6'h3A, 8'hE3); do_wr(6'h3B, 8'hE4);
    check("R3 ext_d", ptr_ext_d, 24'h110000);
    check("R3 ext_x", ptr_ext_x, 24'h220000);
    check("R3 ext_y", ptr_ext_y, 24'h330000);
    check("R3 ext_z", ptr_ext_z, 24'h440000);
    do_rd(6'h3A, v); check("R3 read y", v, 8'h33);
    cfg_yext_en = 1;
    do_wr(6'h3A, 8'h7E);
    check("R3 only y enabled", {ptr_ext_x[23:16], ptr_ext_y[23:16]}, 16'h227E);
    do_wr(6'h3C, 8'h9A);
    check("R4 jmp with enables low", jmp_ext, 24'h9A0000);
  endtask

  task automatic t_stack();
    logic [7:0] v;
    do_wr(6'h3D, 8'h42);
    check("R5 sp lo write", stack_ptr, {SP_INIT[15:8], 8'h42});
    do_rd(6'h3D, v); check("R5 sp lo read", v, 8'h42);
    cfg_sp16 = 0;
    do_wr(6'h3E, 8'h12);
    check("R6 sp hi discarded", stack_ptr, {SP_INIT[15:8], 8'h42});
    cfg_sp16 = 1;
    do_wr(6'h3E, 8'h12);
    check("R6 sp hi written", stack_ptr, 16'h1242);
    do_rd(6'h3E, v); check("R6 sp hi read", v, 8'h12);
  endtask

  task automatic t_status();
    logic [7:0] v;
    do_wr(6'h3F, 8'h96);
    check("R7 status", status, 8'h96);
    do_rd(6'h3F, v); check("R7 status read", v, 8'h96);
  endtask

  task automatic t_forward();
    logic [7:0] v;
    @(negedge clk);
    io_addr = 6'h05; io_wdata = 8'h77; io_wr = 1'b1;
    #1;
    check("R8 req on write", bus_req, 1);
    check("R8 we", bus_we, 1);
    check("R8 addr", bus_addr, IO_BASE + 16'h05);
    check("R8 wdata", bus_wdata, 8'h77);
    @(negedge clk);
    io_wr = 1'b0;
    #1;
    check("R8 strobe drops", bus_req, 0);
    check("R8 status kept", status, 8'h96);
    check("R8 sp kept", stack_ptr, 16'h1242);
    @(negedge clk);
    io_addr = 6'h37; io_rd = 1'b1;
    #1;
    check("R8 read req", {bus_req, bus_we}, 2'b10);
    check("R8 read addr", bus_addr, IO_BASE + 16'h37);
    v = io_rdata;
    check("R8 read data", v, (IO_BASE[7:0] + 8'h37) ^ 8'hA5);
    io_rd = 1'b0;
    do_rd(6'h00, v);
    check("R8 read port 0", v, IO_BASE[7:0] ^ 8'hA5);
  endtask

  task automatic t_local_no_bus();
    @(negedge clk);
    io_addr = 6'h38; io_rd = 1'b1; io_wr = 1'b1; io_wdata = 8'h01;
    #1 check("R9 no bus on 0x38", bus_req, 0);
    io_addr = 6'h3F;
    #1 check("R9 no bus on 0x3F", bus_req, 0);
    io_rd = 1'b0; io_wr = 1'b0;
    #1;
  endtask

  task automatic t_same_cycle();
    logic [7:0] v;
    do_wr(6'h3F, 8'hC3);
    @(negedge clk);
    io_addr = 6'h3F; io_wdata = 8'h3C; io_wr = 1'b1; io_rd = 1'b1;
    #1 v = io_rdata;
    check("R10 read sees old", v, 8'hC3);
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    #1 check("R10 write lands", status, 8'h3C);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    t_reset();
    t_ext_enabled();
    t_ext_gated();
    t_stack();
    t_status();
    t_forward();
    t_local_no_bus();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule